// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer of a local interrupt controller. Software programs it through a narrow write port that reaches two registers. One is a 32-bit vector entry that describes the interrupt the timer raises. The other is an initial-count register that arms the countdown. A tick-enable input paces the count, one step per enabled cycle. When the count runs out, the block pulses a request carrying the vector, the delivery mode and the trigger type taken from the entry. The pulse is suppressed if the entry is masked.

After an expiry the timer does one of two things. In periodic mode it reloads from the initial count and keeps running. In one-shot mode it parks at zero. The present count is visible at all times on an output port.

Top module: `lirq_timer`

## Requirements
- R1: After reset the current count reads 0 and the request strobe is low.
- R2: A write with select 1 (initial count) loads both the initial-count register and the current count with the written value. The new count is visible one cycle after the write. Writing 0 stops the timer, and later ticks leave the count at 0.
- R3: While the count is non-zero, it falls by exactly one on each cycle with tick enable high and without an initial-count write. Without a tick it holds its value.
- R4: The timer expires on the tick that takes the count from 1 to 0. In the cycle after that tick the request strobe is high for one cycle. It carries the vector from entry bits 7:0, the delivery mode from entry bits 10:8 and the trigger type from entry bit 15.
- R5: When entry bit 16 (mask) is 1 at expiry, no request strobe is produced. The count behaves exactly as when unmasked.
- R6: When entry bit 17 (periodic) is 1, expiry reloads the count from the initial-count register. When it is 0, expiry leaves the count at 0 and no further expiry occurs.
- R7: An initial-count write in the same cycle as a tick takes priority: the count takes the written value and no expiry occurs.
- R8: Select value 0 writes the vector entry and select value 1 writes the initial count. Entry bits 12, 13 and 14 (status, polarity, remote flag) are stored without effect on the timer.
- R9: A vector-entry write leaves the current count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 vector entry, 1 initial count |
| wr_data_i | input | 32 | Write data |
| tick_en_i | input | 1 | Count step enable |
| cur_count_o | output | CntW (32) | Current count |
| irq_req_o | output | 1 | One-cycle interrupt request strobe |
| irq_vec_o | output | 8 | Vector of the request |
| irq_mode_o | output | 3 | Delivery mode of the request |
| irq_level_o | output | 1 | Trigger type of the request (1 level, 0 edge) |

## Verification
Every result is due one cycle after the rising edge that samples the causing write or tick. This covers the loaded count, a decrement, a reload and the request strobe with its fields. The bench drives its inputs on the falling edge and compares the outputs on the next falling edge. Each cycle it compares against a bench-side model that it advances at that rising edge. For this reason a strobe or count change that is early or late by even one cycle is reported. Directed sequences cover expiry at count 1, periodic reload, masking, write-versus-tick collisions and zero writes. A seeded random phase mixes all of these.

// File: rtl/lirq_timer_pkg.sv
package lirq_timer_pkg;

  localparam int EntryW   = 32;
  localparam int VecW     = 8;
  localparam int ModeW    = 3;
  localparam int VecLsb   = 0;
  localparam int ModeLsb  = 8;
  localparam int TrigBit  = 15;
  localparam int MaskBit  = 16;
  localparam int PerBit   = 17;

  typedef enum logic {
    SEL_ENTRY = 1'b0,
    SEL_INIT  = 1'b1
  } wr_sel_e;

  typedef struct packed {
    logic [VecW-1:0]  vector;
    logic [ModeW-1:0] mode;
    logic             level;
    logic             masked;
    logic             periodic;
  } entry_fields_t;

  function automatic entry_fields_t unpack_entry(input logic [EntryW-1:0] raw);
    entry_fields_t f;
    f.vector   = raw[VecLsb +: VecW];
    f.mode     = raw[ModeLsb +: ModeW];
    f.level    = raw[TrigBit];
    f.masked   = raw[MaskBit];
    f.periodic = raw[PerBit];
    return f;
  endfunction

endpackage

// File: rtl/lirq_rst_sync.sv
module lirq_rst_sync #(
  parameter int Stages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [Stages-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[Stages-2:0], 1'b1};
  end

  assign rst_no = sync_q[Stages-1];
endmodule

// File: rtl/lirq_cfg_regs.sv
module lirq_cfg_regs
  import lirq_timer_pkg::*;
#(
  parameter int CntW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  wr_sel_i,
  input  logic [EntryW-1:0]     wr_data_i,
  output entry_fields_t         fields_o,
  output logic [CntW-1:0]       init_o,
  output logic                  load_o,
  output logic [CntW-1:0]       load_val_o
);
  entry_fields_t   fld_q, fld_d;
  logic [CntW-1:0] init_q, init_d;
  logic            fld_en, init_en;
  logic            unused_wr;

  always_comb begin
    fld_en  = wr_en_i & (wr_sel_i == SEL_ENTRY);
    init_en = wr_en_i & (wr_sel_i == SEL_INIT);
    fld_d   = unpack_entry(wr_data_i);
    init_d  = wr_data_i[CntW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fld_q <= '0;
    else if (fld_en) fld_q <= fld_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      init_q <= '0;
    else if (init_en) init_q <= init_d;
  end

  assign unused_wr  = ^wr_data_i;
  assign fields_o   = fld_q;
  assign init_o     = init_q;
  assign load_o     = init_en;
  assign load_val_o = init_d;

  // R8: an entry write must not alter the initial-count register
  a_r8_entry_keeps_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_ENTRY) |=> $stable(init_q));
endmodule

// File: rtl/lirq_downcounter.sv
module lirq_downcounter #(
  parameter int CntW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CntW-1:0] load_val_i,
  input  logic            tick_i,
  input  logic            periodic_i,
  input  logic [CntW-1:0] reload_val_i,
  output logic [CntW-1:0] count_o,
  output logic            expire_o
);
  localparam logic [CntW-1:0] One  = CntW'(1);
  localparam logic [CntW-1:0] Zero = '0;

  logic [CntW-1:0] cnt_q, cnt_d;
  logic            live, step, expire, cnt_en;

  always_comb begin
    live   = (cnt_q != Zero);
    step   = tick_i & ~load_i & live;
    expire = step & (cnt_q == One);
    cnt_en = load_i | step;
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (expire) cnt_d = periodic_i ? reload_val_i : Zero;
    else if (step)   cnt_d = cnt_q - One;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o  = cnt_q;
  assign expire_o = expire;

  // R2: a load is visible the next cycle
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R3: decrement by one per tick above one
  a_r3_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q > One) |=> (cnt_q == $past(cnt_q) - One));
  // R3: no tick, no load, no change
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R6: periodic reload on expiry
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == One && periodic_i) |=> (cnt_q == $past(reload_val_i)));
  // R6: one-shot parks at zero
  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == Zero) |=> (cnt_q == Zero));
endmodule

// File: rtl/lirq_req_gen.sv
module lirq_req_gen
  import lirq_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  input  entry_fields_t    fields_i,
  output logic             req_o,
  output logic [VecW-1:0]  vec_o,
  output logic [ModeW-1:0] mode_o,
  output logic             level_o
);
  logic             req_q, req_d, cap_en;
  logic [VecW-1:0]  vec_q;
  logic [ModeW-1:0] mode_q;
  logic             level_q;

  always_comb begin
    req_d  = expire_i & ~fields_i.masked;
    cap_en = req_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      mode_q  <= '0;
      level_q <= 1'b0;
    end else if (cap_en) begin
      vec_q   <= fields_i.vector;
      mode_q  <= fields_i.mode;
      level_q <= fields_i.level;
    end
  end

  assign req_o   = req_q;
  assign vec_o   = vec_q;
  assign mode_o  = mode_q;
  assign level_o = level_q;

  // R5: masked expiry raises nothing
  a_r5_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && fields_i.masked) |=> !req_q);
  // R4: unmasked expiry strobes with the entry fields
  a_r4_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !fields_i.masked) |=> (req_q && vec_q == $past(fields_i.vector)
                                        && mode_q == $past(fields_i.mode)));
  // R4: strobe only follows an expiry
  a_r4_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> !req_q);
endmodule

// File: rtl/lirq_timer.sv
module lirq_timer
  import lirq_timer_pkg::*;
#(
  parameter int CntW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [31:0]      wr_data_i,
  input  logic             tick_en_i,
  output logic [CntW-1:0]  cur_count_o,
  output logic             irq_req_o,
  output logic [7:0]       irq_vec_o,
  output logic [2:0]       irq_mode_o,
  output logic             irq_level_o
);
  logic            rst_n;
  entry_fields_t   fields;
  logic [CntW-1:0] init_val, load_val;
  logic            load, expire;

  lirq_rst_sync #(.Stages(2)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  lirq_cfg_regs #(.CntW(CntW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .fields_o  (fields),
    .init_o    (init_val),
    .load_o    (load),
    .load_val_o(load_val)
  );

  lirq_downcounter #(.CntW(CntW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .load_i      (load),
    .load_val_i  (load_val),
    .tick_i      (tick_en_i),
    .periodic_i  (fields.periodic),
    .reload_val_i(init_val),
    .count_o     (cur_count_o),
    .expire_o    (expire)
  );

  lirq_req_gen u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .expire_i(expire),
    .fields_i(fields),
    .req_o   (irq_req_o),
    .vec_o   (irq_vec_o),
    .mode_o  (irq_mode_o),
    .level_o (irq_level_o)
  );

  // R4/R7: a strobe follows a tick at count one with no colliding initial-count write
  a_r7_req_source: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_req_o |-> $past(tick_en_i && cur_count_o == CntW'(1)
                        && !(wr_en_i && wr_sel_i == SEL_INIT)));
  // R9: an entry write without a tick leaves the count alone
  a_r9_entry_no_count: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_ENTRY && !tick_en_i) |=> $stable(cur_count_o));
endmodule

// File: tb/lirq_timer_bench.sv
module lirq_timer_bench;
  logic        clk, rst_n, wr_en, wr_sel, tick_en;
  logic [31:0] wr_data, cur_count;
  logic        irq_req, irq_level;
  logic [7:0]  irq_vec;
  logic [2:0]  irq_mode;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] m_cnt, m_init, m_entry;
  logic        exp_req;
  logic [7:0]  exp_vec;
  logic [2:0]  exp_mode;
  logic        exp_level;

  lirq_timer u_lirq_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tick_en_i(tick_en), .cur_count_o(cur_count),
    .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_mode_o(irq_mode),
    .irq_level_o(irq_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mk_entry(input logic [7:0] vec, input logic [2:0] mode,
                                            input logic trig, input logic mask, input logic per);
    logic [31:0] e;
    e = 32'h0000_7000;  // status, polarity, remote flag set: must be inert (R8)
    e[7:0]  = vec;
    e[10:8] = mode;
    e[15]   = trig;
    e[16]   = mask;
    e[17]   = per;
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic wr, input logic sel, input logic [31:0] d, input logic tk);
    exp_req = 1'b0;
    if (wr && sel) begin
      m_init = d;
      m_cnt  = d;
    end else begin
      if (tk && m_cnt != 0) begin
        if (m_cnt == 1) begin
          exp_req   = !m_entry[16];
          exp_vec   = m_entry[7:0];
          exp_mode  = m_entry[10:8];
          exp_level = m_entry[15];
          m_cnt     = m_entry[17] ? m_init : 32'd0;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      if (wr) m_entry = d;
    end
  endtask

  task automatic step(input logic wr, input logic sel, input logic [31:0] d,
                      input logic tk, input string tag);
    wr_en = wr; wr_sel = sel; wr_data = d; tick_en = tk;
    @(posedge clk);
    model(wr, sel, d, tk);
    @(negedge clk);
    chk(tag, "count", cur_count, m_cnt);
    chk(tag, "req", {31'd0, irq_req}, {31'd0, exp_req});
    if (exp_req) begin
      chk("R4", "vector", {24'd0, irq_vec}, {24'd0, exp_vec});
      chk("R4", "mode", {29'd0, irq_mode}, {29'd0, exp_mode});
      chk("R4", "trigger", {31'd0, irq_level}, {31'd0, exp_level});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    wr_en = 0; wr_sel = 0; wr_data = 0; tick_en = 0;
    m_cnt = 0; m_init = 0; m_entry = 0; exp_req = 0;
    exp_vec = 0; exp_mode = 0; exp_level = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "count", cur_count, 32'd0);
    chk("R1", "req", {31'd0, irq_req}, 32'd0);

    // R8/R9: entry write, count untouched
    step(1, 0, mk_entry(8'h3A, 3'd5, 1, 0, 0), 0, "R9");
    // R2: load 5
    step(1, 1, 32'd5, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R3");
    step(1, 0, mk_entry(8'h3A, 3'd5, 1, 0, 0), 0, "R9");
    // R4: one-shot expiry on fifth tick
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, "R4");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R6");
    // R6: periodic reload
    step(1, 0, mk_entry(8'h41, 3'd0, 0, 0, 1), 0, "R8");
    step(1, 1, 32'd3, 0, "R2");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R6");
    // R5: masked periodic
    step(1, 0, mk_entry(8'h77, 3'd2, 1, 1, 1), 0, "R5");
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, "R5");
    // R7: write and tick together, including at count 1
    step(1, 0, mk_entry(8'h12, 3'd4, 1, 0, 0), 0, "R8");
    step(1, 1, 32'd1, 0, "R2");
    step(1, 1, 32'd4, 1, "R7");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1, "R3");
    // R2: zero write stops
    step(1, 1, 32'd0, 1, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R2");
    // R4: count 1 expires on the next tick
    step(1, 1, 32'd1, 0, "R2");
    step(0, 0, 0, 1, "R4");

    for (int i = 0; i < 3000; i++) begin
      logic        w, s, t;
      logic [31:0] d;
      w = ($urandom % 10) == 0;
      s = $urandom % 2;
      t = ($urandom % 10) < 7;
      d = s ? ($urandom % 9) : $urandom;
      step(w, s, d, t, "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule